// File: doc/BRIEF.md
# Shift-Register Stochastic Bit Shuffler

This cell takes two stochastic bitstreams, `a` and `b`, one bit per clock. It produces one output bitstream `c` that keeps the probability a Muller C-element would give those inputs, with much less autocorrelation. A cycle is called regenerative when the two inputs agree. In such a cycle the agreed bit is both emitted and pushed into a store of 2^IDX_W past bits. When the inputs disagree, the cell does not hold its last output the way a C-element would. It emits one of the stored past regenerative bits instead, so runs of equal bits are broken up and no new random bits are created.

A compile-time mode chooses how that stored bit is picked. In indexed mode, the store stays as it is and an internal 16-bit LFSR gives the read position. In rotating mode, the store rotates by one place toward position 0 and the bit that leaves position 0 is emitted, so no random source is built. The output is registered. Cells of this kind replace the plain C-elements of a stochastic inference tree, one cell for each tree node.

Top module: `stoch_shuffle`

## Requirements
- R1: In a cycle where `a` equals `b`, the output `c` after the next rising clock edge equals `a`, in both modes.
- R2: In a cycle where `a` equals `b`, the store shifts one place toward higher positions and `a` is written into position 0. The oldest bit, at position 2^IDX_W-1, is dropped.
- R3: In indexed mode (MODE = SHUF_EDGE), a cycle where `a` differs from `b` leaves the store unchanged. The output becomes the stored bit at the position given by the low IDX_W bits of the LFSR state in that cycle.
- R4: The LFSR is 16 bits wide and is loaded with RND_SEED on reset. It advances on every clock after reset, whatever the inputs, as state <= {state[14:0], state[15]^state[13]^state[12]^state[10]}.
- R5: In rotating mode (MODE = SHUF_ROTATE), a cycle where `a` differs from `b` moves every stored bit from position j+1 down to position j. The bit at position 0 moves to position 2^IDX_W-1, and that same bit becomes the output.
- R6: While `rst_n` is low, `c` is 0 and the LFSR holds RND_SEED. The store position j holds 1 when j is even and 0 when j is odd.
- R7: `c` is registered. A change on `a` or `b` has no effect on `c` until the next rising clock edge.
- R8: In rotating mode, 2^IDX_W back-to-back disagreeing cycles bring the store back to its starting content. The output sequence over the next 2^IDX_W such cycles repeats the one before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| a | input | 1 | First input bitstream |
| b | input | 1 | Second input bitstream |
| c | output | 1 | Rerandomized output bitstream, registered |

## Verification
The assertions assume that `a` and `b` carry known values at every rising edge. They also assume that reset is held low across at least one rising edge before the first checked cycle, because every store and output property compares against the bits sampled one edge earlier. The stimulus meets both conditions. Inputs change only on falling edges and always come from defined values. Every reset, including the one issued in the middle of the run, is held for three full clock periods. Stimulus covers every sequence of four input pairs, long runs of agreement, and long runs of disagreement.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

    typedef enum logic {
        SHUF_EDGE   = 1'b0,
        SHUF_ROTATE = 1'b1
    } shuf_mode_e;

    localparam int unsigned RND_W = 16;

    // Maximal-length Fibonacci step, taps at bits 15, 13, 12, 10.
    function automatic logic [RND_W-1:0] rnd_advance(input logic [RND_W-1:0] s);
        return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/shuf_rng.sv
module shuf_rng
    import shuf_pkg::*;
#(
    parameter int unsigned      OUT_W = 4,
    parameter logic [RND_W-1:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] idx
);

    typedef struct packed {
        logic [RND_W-1:0] lfsr;
    } rng_t;

    rng_t rng_d, rng_q;

    always_comb begin
        rng_d      = rng_q;
        rng_d.lfsr = rnd_advance(rng_q.lfsr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rng_q.lfsr <= SEED;
        end else begin
            rng_q <= rng_d;
        end
    end

    assign idx = rng_q.lfsr[OUT_W-1:0];

endmodule

// File: rtl/shuf_store.sv
module shuf_store
    import shuf_pkg::*;
#(
    parameter int unsigned IDX_W = 4,
    parameter shuf_mode_e  MODE  = SHUF_EDGE,
    localparam int unsigned DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a,
    input  logic             b,
    input  logic [IDX_W-1:0] idx,
    output logic [DEPTH-1:0] store,
    output logic             c
);

    localparam logic [DEPTH-1:0] FILL = {(DEPTH/2){2'b01}};

    typedef struct packed {
        logic [DEPTH-1:0] mem;
        logic             out;
    } cell_t;

    cell_t cell_d, cell_q;

    logic             regen;
    logic [DEPTH-1:0] idle_mem;

    assign regen = (a == b);

    // Store content on a disagreeing cycle depends on the mode.
    generate
        if (MODE == SHUF_ROTATE) begin : g_rotate
            assign idle_mem = {cell_q.mem[0], cell_q.mem[DEPTH-1:1]};
        end else begin : g_hold
            assign idle_mem = cell_q.mem;
        end
    endgenerate

    always_comb begin
        cell_d = cell_q;
        if (regen) begin
            cell_d.mem = {cell_q.mem[DEPTH-2:0], a};
            cell_d.out = a;
        end else begin
            cell_d.mem = idle_mem;
            // idx is tied to zero in rotating mode, so this reads the bit leaving position 0
            cell_d.out = cell_q.mem[idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q.mem <= FILL;
            cell_q.out <= 1'b0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign store = cell_q.mem;
    assign c     = cell_q.out;

endmodule

// File: rtl/stoch_shuffle.sv
module stoch_shuffle
    import shuf_pkg::*;
#(
    parameter int unsigned      IDX_W    = 4,
    parameter shuf_mode_e       MODE     = SHUF_EDGE,
    parameter logic [RND_W-1:0] RND_SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic c
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0] idx_w;
    logic [DEPTH-1:0] store_w;

    generate
        if (MODE == SHUF_EDGE) begin : g_rng
            shuf_rng #(
                .OUT_W (IDX_W),
                .SEED  (RND_SEED)
            ) rng_i (
                .clk   (clk),
                .rst_n (rst_n),
                .idx   (idx_w)
            );
        end else begin : g_no_rng
            assign idx_w = '0;
        end
    endgenerate

    shuf_store #(
        .IDX_W (IDX_W),
        .MODE  (MODE)
    ) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (a),
        .b     (b),
        .idx   (idx_w),
        .store (store_w),
        .c     (c)
    );

endmodule

// File: rtl/shuf_checker.sv
module shuf_checker #(
    parameter int unsigned N     = 16,
    parameter int unsigned IDX_W = 4,
    parameter bit          ROT   = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a,
    input logic             b,
    input logic             c,
    input logic [N-1:0]     store,
    input logic [IDX_W-1:0] idx
);

    // R6: output cleared by reset
    a_r6_reset_out: assert property (@(posedge clk) !rst_n |=> c == 1'b0);

    // R1: agreeing inputs reach the output one edge later
    a_r1_regen_out: assert property (@(posedge clk) disable iff (!rst_n)
        (a == b) |=> c == $past(a));

    // R2: agreeing inputs shift the store upward
    a_r2_regen_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (a == b) |=> (store[0] == $past(a)) && (store[N-1:1] == $past(store[N-2:0])));

    // R3, R5: a disagreeing cycle emits the stored bit at the read position
    a_r3_r5_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (a != b) |=> c == $past(store[idx]));

    generate
        if (ROT) begin : g_rot
            // R5: output is the bit that left position 0
            a_r5_rotate_out: assert property (@(posedge clk) disable iff (!rst_n)
                (a != b) |=> c == $past(store[0]));
            // R5: rotation toward position 0 with wrap to the top
            a_r5_rotate_wrap: assert property (@(posedge clk) disable iff (!rst_n)
                (a != b) |=> (store[N-1] == $past(store[0])) && (store[N-2:0] == $past(store[N-1:1])));
        end else begin : g_idx
            // R3: store untouched on disagreeing cycles
            a_r3_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (a != b) |=> $stable(store));
        end
    endgenerate

endmodule

bind stoch_shuffle shuf_checker #(
    .N     (DEPTH),
    .IDX_W (IDX_W),
    .ROT   (MODE == SHUF_ROTATE)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (a),
    .b     (b),
    .c     (c),
    .store (store_w),
    .idx   (idx_w)
);

// File: tb/stoch_shuffle_tb_top.sv
module stoch_shuffle_tb_top;
    import shuf_pkg::*;

    localparam int unsigned IW   = 4;
    localparam int unsigned N    = 1 << IW;
    localparam logic [15:0] SEED = 16'hACE1;
    localparam logic [N-1:0] FILL = {(N/2){2'b01}};

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic a     = 1'b0;
    logic b     = 1'b0;
    logic c_e;
    logic c_r;

    always #10 clk = ~clk;

    stoch_shuffle #(.IDX_W(IW), .MODE(SHUF_EDGE), .RND_SEED(SEED)) dut_i (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .c(c_e)
    );

    stoch_shuffle #(.IDX_W(IW), .MODE(SHUF_ROTATE), .RND_SEED(SEED)) dut_rot_i (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .c(c_r)
    );

    int checks = 0;
    int fails  = 0;
    logic [N-1:0] me, mr;
    logic [15:0]  ml;
    logic         pe, pr;
    logic [31:0]  xs = 32'h1234_5678;

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        a = 1'b0;
        b = 1'b0;
        me = FILL; mr = FILL; ml = SEED; pe = 1'b0; pr = 1'b0;
        repeat (3) @(negedge clk);
        chk(c_e, 1'b0, "R6 edge reset output");
        chk(c_r, 1'b0, "R6 rotate reset output");
        rst_n = 1'b1;
    endtask

    // Called at a falling edge; drives one input pair and checks the result.
    task automatic step(input logic ai, input logic bi, input string ovr);
        logic  ee, er;
        string te, tr;
        a = ai;
        b = bi;
        #1;
        chk(c_e, pe, "R7 edge output held before edge");
        chk(c_r, pr, "R7 rotate output held before edge");
        if (ai == bi) begin
            ee = ai; er = ai;
            me = {me[N-2:0], ai};
            mr = {mr[N-2:0], ai};
            te = "R1 edge regen"; tr = "R1 rotate regen";
        end else begin
            ee = me[ml[IW-1:0]];
            er = mr[0];
            mr = {mr[0], mr[N-1:1]};
            te = "R3 R4 edge indexed pick"; tr = "R5 rotate pick";
        end
        ml = {ml[14:0], ml[15] ^ ml[13] ^ ml[12] ^ ml[10]};
        if (ovr != "") begin te = ovr; tr = ovr; end
        @(posedge clk);
        @(negedge clk);
        chk(c_e, ee, te);
        chk(c_r, er, tr);
        pe = ee;
        pr = er;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog expired: got running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] pat;
        do_reset();
        // Reset fill read back through disagreeing cycles
        for (int i = 0; i < N; i++) step(1'b1, 1'b0, "R6 fill read back");
        for (int i = 0; i < N; i++) step(1'b0, 1'b1, "R8 rotation period");
        // Load a known pattern, then read the stored order
        pat = 16'hB4C9;
        for (int i = 0; i < N; i++) step(pat[i % 16], pat[i % 16], "R2 load");
        for (int i = 0; i < N; i++) step(1'b0, 1'b1, "R2 stored order");
        // Every sequence of four input pairs
        for (int s = 0; s < 256; s++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] sv;
                sv = 8'(s);
                step(sv[2*k+1], sv[2*k], "");
            end
        end
        // Long runs of agreement and disagreement
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1, "");
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1, "");
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0, "");
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, "");
        // Pseudo-random pairs
        for (int i = 0; i < 3000; i++) begin
            xs = xs ^ (xs << 13);
            xs = xs ^ (xs >> 17);
            xs = xs ^ (xs << 5);
            step(xs[3], xs[11], "");
        end
        // Reset in mid-run restores fill and seed
        do_reset();
        for (int i = 0; i < N; i++) step(1'b0, 1'b1, "R6 fill after second reset");
        for (int i = 0; i < 200; i++) step(i[0] & i[2], i[1], "");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule